// File: doc/BRIEF.md
# Command-Armed Oversampling Serial Receiver

This block is the receive half of a serial engine. It sits idle until software writes a start-read opcode into its secondary command register. From then on it watches the serial line with 32x oversampling, assembles 8-bit characters and stores each good character in a receive queue. Software reads characters one at a time through a data register and reads the number of stored words from a count register. Writing the abort bit in the command-control register ends reception. That bit reads back as 1 until the abort sequence has finished.

Four secondary interrupt sources are kept in a status register:
- receive watermark reached;
- last data, raised when the line has been quiet for 160 oversample ticks while data waits in the queue;
- command done;
- abort done.

A source latches only while its enable bit is set. Each status bit is cleared by writing 1 to it. Bit 31 of the main interrupt status register, which also drives the `irq` pin, shows whether any enabled secondary interrupt is pending.

The sequencer has three states, each with named transitions:
- SEQ_IDLE goes to SEQ_READ on a start-read opcode (`arm`).
- SEQ_IDLE or SEQ_READ goes to SEQ_ABORT when the abort bit is written (`kill`).
- SEQ_ABORT returns to SEQ_IDLE after `ABORT_CYCLES` clocks (`retire`).

The character receiver has four states:
- RXS_IDLE goes to RXS_START when a falling edge is seen.
- RXS_START goes to RXS_DATA if the line is still low at tick 16. Otherwise it goes back to RXS_IDLE (the edge was a glitch).
- RXS_DATA goes to RXS_STOP after 8 bits.
- RXS_STOP returns to RXS_IDLE. The character is stored or dropped at that point.

Top module: `rxq_uart_rx`

Register word addresses (`reg_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | command | write |
| 1 | command-control | read/write |
| 2 | general status | read |
| 3 | secondary IRQ status | read, write 1 to clear |
| 4 | secondary IRQ enable | read/write |
| 5 | main IRQ status | read |
| 6 | receive count | read |
| 7 | receive data | read pops |

## Requirements
- R1: Writing the command register with opcode 1 in bits 31:27 starts reception whatever bits 26:0 hold. Any other opcode is ignored. Bit 12 of the general status register reads 1 while a command (read or abort) is active.
- R2: Characters on the line while no read command is active are not stored.
- R3: A start bit is accepted only if the line is still low 16 oversample ticks after the falling edge, so a shorter low pulse stores nothing. The 8 data bits are each sampled 32 ticks apart, LSB first.
- R4: A character whose stop bit samples low is dropped.
- R5: The receive count register holds the stored word count in bits 24:0. A read of the data register returns the oldest character in bits 7:0, removes it from the queue and lowers the count by one.
- R6: When the queue holds FIFO_DEPTH characters, further characters are discarded and the stored ones are kept intact.
- R7: Bit 26 of the secondary status sets when the count is at least WM_LEVEL.
- R8: Bit 27 of the secondary status sets once the line has been idle for STALE_TICKS oversample ticks after the last stored character while the queue is not empty. It does not set before then.
- R9: A secondary status bit latches only while the matching enable bit (same position) is 1. Writing 1 to a status bit clears it.
- R10: Writing 1 to bit 1 of the command-control register aborts. That bit reads 1 until the abort finishes and 0 afterwards. On completion, status bits 5 (abort done) and 0 (command done) set and reception stops.
- R11: Bit 31 of the main IRQ status register and the `irq` output are 1 exactly when some enabled secondary status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| rx_in | input | 1 | Serial line, idle high |
| irq | output | 1 | Pending enabled secondary interrupt |

## Verification
The receiver is driven with the byte patterns A5, 3C, 00, FF, 80 and 01. Alternating bits catch a sampling phase that lands off mid-bit. All-zero and all-one bytes catch lost start or stop detection, and single-bit values catch a reversed bit order. A low pulse shorter than half a bit tells real start confirmation apart from plain edge detection. A frame with a low stop bit tells framing checks apart from blind storing. An overfilled queue, reads before and after the stale window, interrupts with and without their enable bit, and an abort partway through a session check the sequencer and interrupt paths, with a scoreboard queue checking the order of stored data.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        A_CMD     = 3'd0,
        A_CTRL    = 3'd1,
        A_GSTAT   = 3'd2,
        A_SIRQ    = 3'd3,
        A_SIRQ_EN = 3'd4,
        A_MIRQ    = 3'd5,
        A_RXCNT   = 3'd6,
        A_RXDATA  = 3'd7
    } reg_addr_t;

    localparam logic [4:0] OPC_START_READ = 5'd1;

    localparam int B_CMD_DONE   = 0;
    localparam int B_ABORT_DONE = 5;
    localparam int B_RX_WM      = 26;
    localparam int B_RX_LAST    = 27;
    localparam int B_SEC_SUM    = 31;
    localparam int B_SEC_ACTIVE = 12;
    localparam int B_ABORT_REQ  = 1;

    localparam logic [31:0] SIRQ_IMPL =
        (32'd1 << B_CMD_DONE) | (32'd1 << B_ABORT_DONE) |
        (32'd1 << B_RX_WM) | (32'd1 << B_RX_LAST);

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
    import rxq_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int OSR     = 32,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_in,
    output logic              tick,
    output logic              line_idle,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data
);

    localparam int DW  = $clog2(CLK_DIV + 1);
    localparam int OW  = $clog2(OSR);
    localparam int BW  = $clog2(DATA_W + 1);
    localparam int MID = OSR / 2;

    logic [DW-1:0]     div_q;
    logic              rx_meta_q, rx_s_q, prev_q, prev_d;
    rx_state_t         state_q, state_d;
    logic [OW-1:0]     cnt_q, cnt_d;
    logic [BW-1:0]     bits_q, bits_d;
    logic [DATA_W-1:0] shift_q, shift_d;
    logic              push;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    assign tick       = (div_q == DW'(CLK_DIV - 1));
    assign line_idle  = (state_q == RXS_IDLE);
    assign char_valid = valid_q;
    assign char_data  = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            rx_meta_q <= 1'b1;
            rx_s_q    <= 1'b1;
        end else begin
            div_q     <= tick ? '0 : div_q + 1'b1;
            rx_meta_q <= rx_in;
            rx_s_q    <= rx_meta_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= RXS_IDLE;
            cnt_q   <= '0;
            bits_q  <= '0;
            shift_q <= '0;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bits_q  <= bits_d;
            shift_q <= shift_d;
            prev_q  <= prev_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bits_d  = bits_q;
        shift_d = shift_q;
        prev_d  = prev_q;
        push    = 1'b0;
        if (tick && enable) begin
            unique case (state_q)
                RXS_IDLE: begin
                    prev_d = rx_s_q;
                    if (prev_q && !rx_s_q) begin
                        state_d = RXS_START;
                        cnt_d   = '0;
                    end
                end
                RXS_START: begin
                    if (cnt_q == OW'(MID - 1)) begin
                        if (!rx_s_q) begin
                            state_d = RXS_DATA;
                            cnt_d   = '0;
                            bits_d  = '0;
                        end else begin
                            state_d = RXS_IDLE;
                            prev_d  = rx_s_q;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RXS_DATA: begin
                    if (cnt_q == OW'(OSR - 1)) begin
                        cnt_d   = '0;
                        shift_d = {rx_s_q, shift_q[DATA_W-1:1]};
                        if (bits_q == BW'(DATA_W - 1)) state_d = RXS_STOP;
                        else bits_d = bits_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RXS_STOP: begin
                    if (cnt_q == OW'(OSR - 1)) begin
                        push    = rx_s_q;
                        state_d = RXS_IDLE;
                        prev_d  = rx_s_q;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= push;
            if (push) data_q <= shift_q;
        end
    end

    // R3: a start edge that is high again at the confirm tick is rejected
    p_glitch_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == RXS_START && cnt_q == OW'(MID - 1) && rx_s_q)
        |=> (state_q == RXS_IDLE));

    // R4: a low stop sample never produces a character
    p_frame_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_q == RXS_STOP && cnt_q == OW'(OSR - 1) && !rx_s_q)
        |=> !valid_q);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = empty ? '0 : mem_q[rp_q];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= nxt(wp_q);
            if (pop_ok)  rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wp_q == AW'(i)) mem_q[i] <= wdata;
        end
    end

    // R6: a push into a full queue without a pop leaves the count alone
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));

    // R5: a pop on its own lowers the count by one
    p_pop_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/rxq_stale.sv
module rxq_stale #(
    parameter int STALE_TICKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic arm,
    input  logic busy,
    input  logic has_data,
    output logic fire
);

    localparam int TW = $clog2(STALE_TICKS + 1);

    logic          armed_q;
    logic [TW-1:0] cnt_q;
    logic          fire_q;

    assign fire = fire_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (arm) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (busy) begin
                cnt_q <= '0;
            end else if (armed_q && tick) begin
                if (cnt_q == TW'(STALE_TICKS - 1)) begin
                    armed_q <= 1'b0;
                    fire_q  <= has_data;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxq_uart_rx.sv
module rxq_uart_rx
    import rxq_pkg::*;
#(
    parameter int CLK_DIV      = 2,
    parameter int OSR          = 32,
    parameter int FIFO_DEPTH   = 16,
    parameter int WM_LEVEL     = 4,
    parameter int STALE_TICKS  = 160,
    parameter int ABORT_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_in,
    output logic        irq
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam int AC = $clog2(ABORT_CYCLES + 1);

    reg_addr_t   addr;
    seq_state_t  seq_q, seq_d;
    logic [AC-1:0] abt_q, abt_d;
    logic [4:0]  op_q;
    logic [31:0] en_q, sts_q, sts_d, ev, clr;
    logic        abort_done, reading;
    logic        tick, line_idle, rx_valid;
    logic [7:0]  rx_char, fifo_out;
    logic [CW-1:0] fifo_cnt;
    logic        fifo_empty, pop, stale_fire;
    logic        wr_cmd, wr_ctrl;

    assign addr    = reg_addr_t'(reg_addr);
    assign wr_cmd  = reg_wr && addr == A_CMD;
    assign wr_ctrl = reg_wr && addr == A_CTRL && reg_wdata[B_ABORT_REQ];
    assign reading = (seq_q == SEQ_READ);
    assign pop     = reg_rd && addr == A_RXDATA;

    rxq_sampler #(.CLK_DIV(CLK_DIV), .OSR(OSR), .DATA_W(8)) u_samp (
        .clk(clk), .rst_n(rst_n), .enable(reading), .rx_in(rx_in),
        .tick(tick), .line_idle(line_idle),
        .char_valid(rx_valid), .char_data(rx_char)
    );

    rxq_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_valid), .wdata(rx_char),
        .pop(pop), .rdata(fifo_out), .count(fifo_cnt), .empty(fifo_empty)
    );

    rxq_stale #(.STALE_TICKS(STALE_TICKS)) u_stale (
        .clk(clk), .rst_n(rst_n), .enable(reading), .tick(tick),
        .arm(rx_valid), .busy(!line_idle), .has_data(!fifo_empty),
        .fire(stale_fire)
    );

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
            abt_q <= '0;
        end else begin
            seq_q <= seq_d;
            abt_q <= abt_d;
        end
    end

    always_comb begin
        seq_d      = seq_q;
        abt_d      = abt_q;
        abort_done = 1'b0;
        unique case (seq_q)
            SEQ_IDLE: begin
                if (wr_ctrl) begin
                    seq_d = SEQ_ABORT;
                    abt_d = '0;
                end else if (wr_cmd && reg_wdata[31:27] == OPC_START_READ) begin
                    seq_d = SEQ_READ;
                end
            end
            SEQ_READ: begin
                if (wr_ctrl) begin
                    seq_d = SEQ_ABORT;
                    abt_d = '0;
                end
            end
            SEQ_ABORT: begin
                if (abt_q == AC'(ABORT_CYCLES - 1)) begin
                    seq_d      = SEQ_IDLE;
                    abort_done = 1'b1;
                end else begin
                    abt_d = abt_q + 1'b1;
                end
            end
        endcase
    end

    // interrupt and register outputs
    always_comb begin
        ev = '0;
        ev[B_CMD_DONE]   = abort_done;
        ev[B_ABORT_DONE] = abort_done;
        ev[B_RX_WM]      = (fifo_cnt >= CW'(WM_LEVEL));
        ev[B_RX_LAST]    = stale_fire;
        clr   = (reg_wr && addr == A_SIRQ) ? reg_wdata : '0;
        sts_d = ((sts_q & ~clr) | (ev & en_q)) & SIRQ_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_cmd) op_q <= reg_wdata[31:27];
            if (reg_wr && addr == A_SIRQ_EN) en_q <= reg_wdata & SIRQ_IMPL;
        end
    end

    assign irq = |(sts_q & en_q);

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_CMD:     reg_rdata[31:27]      = op_q;
            A_CTRL:    reg_rdata[B_ABORT_REQ] = (seq_q == SEQ_ABORT);
            A_GSTAT:   reg_rdata[B_SEC_ACTIVE] = (seq_q != SEQ_IDLE);
            A_SIRQ:    reg_rdata             = sts_q;
            A_SIRQ_EN: reg_rdata             = en_q;
            A_MIRQ:    reg_rdata[B_SEC_SUM]  = irq;
            A_RXCNT:   reg_rdata[24:0]       = 25'(fifo_cnt);
            A_RXDATA:  reg_rdata[7:0]        = fifo_out;
        endcase
    end

    // R2: no character leaves the receiver one cycle after reading stopped
    p_rx_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q != SEQ_READ) |=> !rx_valid);

    // R9: the last-data bit cannot rise while its enable was clear
    p_gate_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[B_RX_LAST] |=> !$rose(sts_q[B_RX_LAST]));

    // R10: an abort always drains back to idle with done flags if enabled
    p_abort_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SEQ_ABORT && abt_q == AC'(ABORT_CYCLES - 1) && en_q[B_ABORT_DONE])
        |=> (seq_q == SEQ_IDLE && sts_q[B_ABORT_DONE]));

endmodule

// File: tb/rxq_uart_rx_tb.sv
module rxq_uart_rx_tb;

    localparam int CLK_DIV  = 2;
    localparam int OSR      = 32;
    localparam int DEPTH    = 16;
    localparam int WM       = 4;
    localparam int STALE    = 160;
    localparam int ABORTC   = 4;
    localparam int BIT_CLKS = CLK_DIV * OSR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_in = 1'b1;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    rxq_uart_rx #(
        .CLK_DIV(CLK_DIV), .OSR(OSR), .FIFO_DEPTH(DEPTH), .WM_LEVEL(WM),
        .STALE_TICKS(STALE), .ABORT_CYCLES(ABORTC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_in(rx_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic hold_line(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // driver: sends one frame, queues the expected byte when it should land
    task automatic send_char(input logic [7:0] b, input logic stop_ok, input logic expect_it);
        if (expect_it) exp_q.push_back(b);
        @(negedge clk);
        hold_line(1'b0);
        for (int i = 0; i < 8; i++) hold_line(b[i]);
        hold_line(stop_ok);
        hold_line(1'b1);
    endtask

    // monitor: pops every stored word and compares against the queue
    task automatic drain(input string req);
        logic [31:0] cnt, d;
        rd_reg(3'd6, cnt);
        for (int i = 0; i < int'(cnt); i++) begin
            rd_reg(3'd7, d);
            if (exp_q.size() == 0) check(req, d, 32'hDEAD);
            else check(req, d, {24'h0, exp_q.pop_front()});
        end
        check({req, " leftover"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        rd_reg(3'd6, v); check("R5 reset count", v, 0);
        rd_reg(3'd3, v); check("R9 reset status", v, 0);
        rd_reg(3'd2, v); check("R1 reset idle", v, 0);
        check("R11 reset irq", {31'h0, irq}, 0);

        // R2: line activity before any read command
        send_char(8'h5A, 1'b1, 1'b0);
        rd_reg(3'd6, v); check("R2 idle ignores line", v, 0);

        // R1: foreign opcode ignored, start-read with junk params accepted
        wr_reg(3'd0, {5'd2, 27'h0});
        rd_reg(3'd2, v); check("R1 opcode 2 ignored", v & 32'h1000, 0);
        wr_reg(3'd0, {5'd1, 27'h5A5A5A5});
        rd_reg(3'd2, v); check("R1 active bit", v & 32'h1000, 32'h1000);

        // R3: short low pulse
        @(negedge clk); rx_in = 1'b0;
        repeat (10 * CLK_DIV) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        rd_reg(3'd6, v); check("R3 glitch rejected", v, 0);

        // R3/R5: pattern set
        send_char(8'hA5, 1'b1, 1'b1);
        send_char(8'h3C, 1'b1, 1'b1);
        send_char(8'h00, 1'b1, 1'b1);
        rd_reg(3'd6, v); check("R5 count three", v, 3);
        send_char(8'hFF, 1'b1, 1'b1);
        send_char(8'h80, 1'b1, 1'b1);
        send_char(8'h01, 1'b1, 1'b1);
        drain("R3 pattern order");
        rd_reg(3'd6, v); check("R5 count after drain", v, 0);

        // R4: framing error
        send_char(8'h77, 1'b0, 1'b0);
        rd_reg(3'd6, v); check("R4 bad stop dropped", v, 0);
        send_char(8'h42, 1'b1, 1'b1);
        drain("R4 recovery");

        // R7/R11: watermark
        wr_reg(3'd4, 32'h1 << 26);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        for (int i = 0; i < WM - 1; i++) send_char(8'h10 + 8'(i), 1'b1, 1'b1);
        rd_reg(3'd3, v); check("R7 below level", v & (32'h1 << 26), 0);
        check("R11 irq low", {31'h0, irq}, 0);
        send_char(8'h1F, 1'b1, 1'b1);
        rd_reg(3'd3, v); check("R7 at level", v & (32'h1 << 26), 32'h1 << 26);
        rd_reg(3'd5, v); check("R11 summary bit", v, 32'h8000_0000);
        check("R11 irq high", {31'h0, irq}, 1);
        drain("R7 data");
        wr_reg(3'd3, 32'h1 << 26);
        rd_reg(3'd3, v); check("R9 w1c clears", v, 0);
        check("R11 irq drops", {31'h0, irq}, 0);

        // R9: stale condition with its enable clear
        send_char(8'h66, 1'b1, 1'b1);
        repeat (500) @(negedge clk);
        rd_reg(3'd3, v); check("R9 disabled no latch", v & (32'h1 << 27), 0);
        drain("R9 data");

        // R8: stale timeout
        wr_reg(3'd4, 32'h0C00_0021);
        send_char(8'h99, 1'b1, 1'b1);
        rd_reg(3'd3, v); check("R8 not yet", v & (32'h1 << 27), 0);
        repeat (300) @(negedge clk);
        rd_reg(3'd3, v); check("R8 last-data set", v & (32'h1 << 27), 32'h1 << 27);
        wr_reg(3'd3, 32'h1 << 27);
        rd_reg(3'd3, v); check("R9 w1c last", v & (32'h1 << 27), 0);
        drain("R8 data");

        // R6: overfill
        for (int i = 0; i < DEPTH + 2; i++)
            send_char(8'h40 + 8'(i), 1'b1, i < DEPTH);
        rd_reg(3'd6, v); check("R6 count capped", v, DEPTH);
        drain("R6 order kept");
        repeat (400) @(negedge clk);
        wr_reg(3'd3, 32'hFFFF_FFFF);

        // R10: abort
        wr_reg(3'd1, 32'h2);
        rd_reg(3'd1, v); check("R10 abort pending", v, 32'h2);
        repeat (ABORTC + 2) @(negedge clk);
        rd_reg(3'd1, v); check("R10 abort self-clears", v, 0);
        rd_reg(3'd3, v); check("R10 done flags", v & 32'h21, 32'h21);
        rd_reg(3'd2, v); check("R10 inactive", v & 32'h1000, 0);
        send_char(8'h3E, 1'b1, 1'b0);
        rd_reg(3'd6, v); check("R2 after abort ignored", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule